// File: doc/BRIEF.md
# Calibration Loop Recovery Sequencer

This block watches over the reference-locked fine-trim loop of a full-speed USB device. That loop trims a local oscillator against the 1 kHz start-of-frame stream. The block follows bus traffic. It declares suspend after 3 ms with no bus activity, and it keeps the trim loop switched off while the bus is suspended, so that the missing reference events cannot pull the trim code down.

Some bus events can leave the loop stuck with its trim collapsed. After every bus reset, the sequencer runs a recovery cycle at once: it switches the loop off, waits until the loop confirms that it is off (or until a short timeout expires), then switches it back on. After a resume, the sequencer does not recover at once. It raises a pending mark. It then inspects the trim code on the first start-of-frame that follows, and runs the recovery cycle only if that code has fallen to 1. Once any recovery has finished, the sequencer leaves the loop a settling window of 7 ms, during which a pending check is held back.

A saturating counter reports how many recovery cycles have completed. The idle timer and the settling window count a 1 µs tick strobe, which is supplied from outside.

Top module: `calib_recovery_seq`

## Requirements
- R1: After reset, loopEnable is 1, suspended is 0 and recoveryCount is 0.
- R2: suspended rises on the 3000th consecutive tickUs strobe with no bus activity, counting from the last activity. After 2999 such strobes it is still 0.
- R3: Any bus activity (busActivity, sofPulse, busResetPulse or resumePulse) clears suspended in the following cycle and restarts the idle count.
- R4: loopEnable is 0 whenever suspended is 1.
- R5: A busResetPulse while no recovery is running drives loopEnable to 0 in the following cycle.
- R6: During a recovery, a loopOffAck pulse ends the recovery. loopEnable is 1 in the next cycle and recoveryCount has grown by one.
- R7: If no loopOffAck arrives, a recovery ends by itself after 16 cycles with loopEnable at 0, and recoveryCount grows by one.
- R8: A resumePulse by itself never starts a recovery. It only sets a pending mark.
- R9: The first sofPulse that sees the pending mark clears that mark. If trimCode equals 1 at that sofPulse, a recovery starts (loopEnable is 0 in the next cycle). With any other code nothing happens, and later start-of-frames start nothing.
- R10: For 7000 tickUs strobes after a recovery ends, sofPulse leaves the pending mark untouched. The first sofPulse after the window performs the check described in R9.
- R11: recoveryCount stops at 255 and does not wrap.
- R12: A busResetPulse that arrives while a recovery is already running starts no second recovery. The acknowledge adds only one to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickUs | input | 1 | One-cycle strobe, once per microsecond |
| busActivity | input | 1 | Pulse for any other bus traffic seen |
| sofPulse | input | 1 | Start-of-frame received |
| busResetPulse | input | 1 | Bus reset detected |
| resumePulse | input | 1 | Resume signalling detected |
| trimCode | input | 7 | Current fine trim code of the calibration loop |
| loopOffAck | input | 1 | Calibration loop reports that it is disabled |
| loopEnable | output | 1 | Enable for the calibration loop |
| suspended | output | 1 | Bus is in suspend |
| recoveryCount | output | 8 | Saturating count of completed recoveries |

## Verification
Every result becomes visible one cycle after the edge that samples its cause. loopEnable falls in the cycle after a bus reset or a qualifying start-of-frame. It rises, and the count steps, in the cycle after the acknowledge. suspended rises after the 3000th idle tick. Without an acknowledge, loopEnable stays low for exactly 16 cycles. The bench drives every stimulus on the falling edge and reads outputs on the next falling edge, after the sampling rising edge. It counts edges explicitly for the 16-cycle timeout and the 3000-tick idle limit, and it steps over the 7000-tick settling window with margin.

// File: rtl/calib_rec_pkg.sv
package calib_rec_pkg;
  typedef enum logic {ST_RUN, ST_WAIT} recState_t;

  typedef struct packed {
    logic clrWait;
    logic recDone;
  } recStrobe_t;

  typedef struct packed {
    logic waitExpired;
    logic settling;
  } recStatus_t;
endpackage

// File: rtl/calib_rec_dp.sv
module calib_rec_dp
  import calib_rec_pkg::*;
#(
  parameter int IDLE_TICKS   = 3000,
  parameter int ACK_TIMEOUT  = 16,
  parameter int SETTLE_TICKS = 7000,
  parameter int CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickUs,
  input  logic             activity,
  input  recStrobe_t       strobe,
  output recStatus_t       status,
  output logic             suspended,
  output logic [CNT_W-1:0] recCount
);
  localparam int IDLE_W = $clog2(IDLE_TICKS + 1);
  localparam int WAIT_W = $clog2(ACK_TIMEOUT + 1);
  localparam int SETL_W = $clog2(SETTLE_TICKS + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_TICKS - 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX  = IDLE_W'(IDLE_TICKS);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(ACK_TIMEOUT - 1);
  localparam logic [SETL_W-1:0] SETL_INIT = SETL_W'(SETTLE_TICKS);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

  logic [IDLE_W-1:0] idleCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [SETL_W-1:0] settleCnt;

  // bus idle timer and suspend flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt   <= '0;
      suspended <= 1'b0;
    end else if (activity) begin
      idleCnt   <= '0;
      suspended <= 1'b0;
    end else if (tickUs) begin
      if (idleCnt != IDLE_MAX) idleCnt <= idleCnt + 1'b1;
      if (idleCnt == IDLE_LAST) suspended <= 1'b1;
    end
  end

  // acknowledge timeout during a recovery
  always_ff @(posedge clk) begin
    if (!rstN) waitCnt <= '0;
    else if (strobe.clrWait) waitCnt <= '0;
    else if (waitCnt != WAIT_LAST) waitCnt <= waitCnt + 1'b1;
  end

  // settling window after a recovery
  always_ff @(posedge clk) begin
    if (!rstN) settleCnt <= '0;
    else if (strobe.recDone) settleCnt <= SETL_INIT;
    else if (tickUs && settleCnt != '0) settleCnt <= settleCnt - 1'b1;
  end

  // saturating recovery counter
  always_ff @(posedge clk) begin
    if (!rstN) recCount <= '0;
    else if (strobe.recDone && recCount != CNT_MAX) recCount <= recCount + 1'b1;
  end

  assign status.waitExpired = (waitCnt == WAIT_LAST);
  assign status.settling    = (settleCnt != '0);

  p_idle_limit_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspended) |-> ($past(idleCnt) == IDLE_LAST && $past(tickUs)));
  p_activity_wakes_r3: assert property (@(posedge clk) disable iff (!rstN)
    activity |=> !suspended);
  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.recDone |=> $stable(recCount));
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    recCount == CNT_MAX |=> recCount == CNT_MAX);
endmodule

// File: rtl/calib_rec_ctrl.sv
module calib_rec_ctrl
  import calib_rec_pkg::*;
#(
  parameter int CODE_W     = 7,
  parameter int STUCK_CODE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busResetPulse,
  input  logic              resumePulse,
  input  logic              sofPulse,
  input  logic              loopOffAck,
  input  logic [CODE_W-1:0] trimCode,
  input  recStatus_t        status,
  output recStrobe_t        strobe,
  output logic              inWait
);
  localparam logic [CODE_W-1:0] STUCK = CODE_W'(STUCK_CODE);

  recState_t state, stateNext;
  logic pending, sofCheck, startRec;

  assign sofCheck = sofPulse && pending && !status.settling && (state == ST_RUN);
  assign startRec = busResetPulse || (sofCheck && trimCode == STUCK);

  always_comb begin
    stateNext      = state;
    strobe.clrWait = 1'b0;
    strobe.recDone = 1'b0;
    unique case (state)
      ST_RUN: if (startRec) begin
        stateNext      = ST_WAIT;
        strobe.clrWait = 1'b1;
      end
      ST_WAIT: if (loopOffAck || status.waitExpired) begin
        stateNext      = ST_RUN;
        strobe.recDone = 1'b1;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_RUN;
      pending <= 1'b0;
    end else begin
      state <= stateNext;
      if (resumePulse) pending <= 1'b1;
      else if (sofCheck) pending <= 1'b0;
    end
  end

  assign inWait = (state == ST_WAIT);

  p_reset_starts_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && busResetPulse) |=> state == ST_WAIT);
  p_ack_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && loopOffAck) |=> state == ST_RUN);
  p_timeout_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && status.waitExpired) |=> state == ST_RUN);
  p_resume_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && resumePulse && !busResetPulse && !sofPulse) |=> state == ST_RUN);
  p_good_trim_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sofCheck && trimCode != STUCK && !busResetPulse && !resumePulse) |=>
      (!pending && state == ST_RUN));
  p_settle_defers_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pending && status.settling && !busResetPulse) |=> pending);
endmodule

// File: rtl/calib_recovery_seq.sv
module calib_recovery_seq
  import calib_rec_pkg::*;
#(
  parameter int IDLE_TICKS   = 3000,
  parameter int ACK_TIMEOUT  = 16,
  parameter int SETTLE_TICKS = 7000,
  parameter int CODE_W       = 7,
  parameter int STUCK_CODE   = 1,
  parameter int CNT_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickUs,
  input  logic              busActivity,
  input  logic              sofPulse,
  input  logic              busResetPulse,
  input  logic              resumePulse,
  input  logic [CODE_W-1:0] trimCode,
  input  logic              loopOffAck,
  output logic              loopEnable,
  output logic              suspended,
  output logic [CNT_W-1:0]  recoveryCount
);
  recStrobe_t strobe;
  recStatus_t status;
  logic inWait, activity;

  assign activity = busActivity | sofPulse | busResetPulse | resumePulse;

  calib_rec_ctrl #(.CODE_W(CODE_W), .STUCK_CODE(STUCK_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .busResetPulse(busResetPulse),
    .resumePulse(resumePulse), .sofPulse(sofPulse), .loopOffAck(loopOffAck),
    .trimCode(trimCode), .status(status), .strobe(strobe), .inWait(inWait)
  );

  calib_rec_dp #(.IDLE_TICKS(IDLE_TICKS), .ACK_TIMEOUT(ACK_TIMEOUT),
                 .SETTLE_TICKS(SETTLE_TICKS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .activity(activity),
    .strobe(strobe), .status(status), .suspended(suspended),
    .recCount(recoveryCount)
  );

  assign loopEnable = !inWait && !suspended;

  p_suspend_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> !loopEnable);
  p_rewait_r12: assert property (@(posedge clk) disable iff (!rstN)
    (inWait && busResetPulse && !loopOffAck && !strobe.recDone) |=> inWait);
endmodule

// File: tb/calib_recovery_seq_bench.sv
module calib_recovery_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE_N     = 3000;
  localparam int TIMEOUT_N  = 16;
  localparam int SETTLE_N   = 7000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickUs = 1'b0, busActivity = 1'b0, sofPulse = 1'b0;
  logic busResetPulse = 1'b0, resumePulse = 1'b0, loopOffAck = 1'b0;
  logic [6:0] trimCode = 7'd40;
  logic loopEnable, suspended;
  logic [7:0] recoveryCount;

  int nChecks = 0, nFails = 0, cycles = 0, expCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  calib_recovery_seq u_calib_recovery_seq (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .busActivity(busActivity),
    .sofPulse(sofPulse), .busResetPulse(busResetPulse), .resumePulse(resumePulse),
    .trimCode(trimCode), .loopOffAck(loopOffAck), .loopEnable(loopEnable),
    .suspended(suspended), .recoveryCount(recoveryCount)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  // let the settling window run out while keeping the bus awake
  task automatic drainSettle();
    busActivity = 1'b1; tickUs = 1'b1;
    step(SETTLE_N + 2);
    busActivity = 1'b0; tickUs = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 loopEnable", loopEnable, 1);
    check("R1 suspended", suspended, 0);
    check("R1 count", recoveryCount, 0);
  endtask

  task automatic testIdle();
    pulse(busActivity);
    tickUs = 1'b1;
    step(IDLE_N - 1);
    check("R2 not yet suspended", suspended, 0);
    step(1);
    check("R2 suspended at limit", suspended, 1);
    check("R4 loop off in suspend", loopEnable, 0);
    tickUs = 1'b0;
    pulse(sofPulse);
    check("R3 sof wakes", suspended, 0);
    check("R4 loop back on", loopEnable, 1);
    tickUs = 1'b1;
    step(IDLE_N);
    check("R2 suspended again", suspended, 1);
    tickUs = 1'b0;
    pulse(busActivity);
    check("R3 activity wakes", suspended, 0);
  endtask

  task automatic testBusReset();
    pulse(busResetPulse);
    check("R5 loop off after reset", loopEnable, 0);
    step(3);
    pulse(busResetPulse);
    check("R12 still recovering", loopEnable, 0);
    pulse(loopOffAck);
    expCount++;
    check("R6 loop on after ack", loopEnable, 1);
    check("R12 single count", recoveryCount, expCount);
    drainSettle();
  endtask

  task automatic testTimeout();
    pulse(busResetPulse);
    step(TIMEOUT_N - 1);
    check("R7 still off before timeout", loopEnable, 0);
    step(1);
    expCount++;
    check("R7 on after timeout", loopEnable, 1);
    check("R7 count", recoveryCount, expCount);
    drainSettle();
  endtask

  task automatic testResumeGood();
    trimCode = 7'd5;
    pulse(resumePulse);
    step(4);
    check("R8 resume alone no recovery", loopEnable, 1);
    pulse(sofPulse);
    check("R9 good trim no recovery", loopEnable, 1);
    trimCode = 7'd1;
    pulse(sofPulse);
    check("R9 mark consumed", loopEnable, 1);
    check("R9 count unchanged", recoveryCount, expCount);
  endtask

  task automatic testResumeStuck();
    trimCode = 7'd1;
    pulse(resumePulse);
    check("R8 pending only", loopEnable, 1);
    pulse(sofPulse);
    check("R9 stuck trim recovers", loopEnable, 0);
    pulse(loopOffAck);
    expCount++;
    check("R9 count after recovery", recoveryCount, expCount);
  endtask

  task automatic testSettle();
    trimCode = 7'd1;
    pulse(resumePulse);
    pulse(sofPulse);
    check("R10 check deferred in window", loopEnable, 1);
    drainSettle();
    check("R10 still on after window", loopEnable, 1);
    pulse(sofPulse);
    check("R10 deferred check runs", loopEnable, 0);
    pulse(loopOffAck);
    expCount++;
    check("R10 count", recoveryCount, expCount);
    trimCode = 7'd40;
  endtask

  task automatic testSaturate();
    for (int i = 0; i < 260; i++) begin
      pulse(busResetPulse);
      pulse(loopOffAck);
    end
    check("R11 saturates", recoveryCount, 255);
    check("R11 loop on", loopEnable, 1);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdle();
    testBusReset();
    testTimeout();
    testResumeGood();
    testResumeStuck();
    testSettle();
    testSaturate();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule